// File: doc/BRIEF.md
# SPI Flash User-Mode Access Port

This block lets a processor reach serial flash devices one byte at a time through an ordinary memory bus. A single request port serves two address spaces. With `bus_win` low, the request goes to a small register file. That file holds one configuration word, whose upper half carries a write-enable bit for each chip select, and one control word per chip select. With `bus_win` high, the request lands in a flash window that is split into equal segments, one per chip select.

When the addressed chip select is in user mode, a window access of one to four bytes is turned into that many SPI byte transfers. Write data goes out least significant byte first. Read data is collected with the first received byte in the lowest lane.

Chip-select lines are not sequenced by hardware. Each line follows a stop bit in its control word, so software frames a flash command by clearing the bit, pushing bytes through the window and setting the bit again. The request side uses a simple hold-until-ready handshake, and only one access is serviced at a time.

Top module: `spi_user_port`

## Requirements
- R1: After reset all `spi_cs_n` lines are high and `spi_sck` is low. The configuration word reads 0, every control word reads 0x0000_0004, and the status word reads 0x0000_0800.
- R2: Register byte offsets, with address bits above 7 zero, are: configuration at 0x00 (read/write, 32 bits), status at 0x08 (read-only), and control word i at 0x10+4·i (read/write, 32 bits). Any other offset reads 0 and ignores writes.
- R3: `spi_cs_n[i]` equals bit 2 of control word i. It changes only on the clock edge that completes a register write, which is the edge that raises `bus_ready`.
- R4: Bits 1:0 of a control word give the mode, where 3 is user mode and 0, 1 and 2 are not. Bits 23:16 hold an opcode that is stored and read back unchanged.
- R5: `bus_size` holds the byte count minus one. A user-mode window read of N bytes runs N SPI transfers, each sending 0x00. Received byte k lands in bits 8k+7:8k, and lanes at or above N read 0.
- R6: A user-mode window write of N bytes sends bytes 0 to N-1 of `bus_wdata` in rising lane order, one transfer each. It needs configuration bit 16+cs set.
- R7: A window write is dropped when configuration bit 16+cs is clear or when the chip select is not in user mode. A dropped write makes no `spi_sck` edge and still completes.
- R8: A window read while the chip select is not in user mode returns 0xFFFF_FFFF and makes no `spi_sck` edge.
- R9: SPI transfers use mode 0 with most significant bit first. `spi_sck` idles low, each half period lasts CLK_DIV clocks, and `spi_miso` is sampled as `spi_sck` rises.
- R10: `bus_ready` is a one-cycle pulse. For register, dropped and refused accesses it is high in the cycle after the accepting edge. For an N-byte transfer it is high after the edge 16·CLK_DIV·N clocks past the accepting edge. A byte is never cut short.
- R11: A window access uses chip select `bus_addr[WIN_BITS+CS_W-1:WIN_BITS]`. An index of NUM_CS or above reads 0, ignores writes and makes no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Request, held until `bus_ready` is seen |
| bus_win | input | 1 | 1 selects the flash window, 0 selects the registers |
| bus_we | input | 1 | 1 for a write |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Byte count minus one (window accesses) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Completion pulse |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Chip-select lines, active low |

## Verification
A behavioural model tracks the configuration and control words. On every clock it predicts each chip-select level, and `spi_sck` being low outside transfers. A flash responder returns a byte stream that differs from position to position, so reads of one, two and four bytes expose lane order and zero fill. Writes of 0xDEADBEEF and a three-byte value tell rising lane order from reversed order and from a size error. Refused cases are compared against an unchanged bit count: a write without its enable, a write in a non-user mode, a read outside user mode and an index past the last chip select. Completion latencies and half periods are measured against the counts in the requirements.

// File: rtl/spi_user_port.sv
module spi_user_port #(
  parameter int NUM_CS   = 3,
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 12,
  parameter int CLK_DIV  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_win,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int DIV_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int WEN_LSB = 16;
  localparam logic [5:0]  W_CONF  = 6'd0;
  localparam logic [5:0]  W_STAT  = 6'd2;
  localparam logic [5:0]  W_CTRL0 = 6'd4;
  localparam logic [31:0] STAT_RST = 32'h0000_0800;
  localparam logic [31:0] CTRL_RST = 32'h0000_0004;
  localparam logic [1:0]  MODE_USER = 2'd3;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  typedef enum logic {ST_IDLE, ST_SHIFT} st_t;

  st_t              st_q;
  logic [31:0]      conf_q;
  logic [31:0]      ctrl_q [NUM_CS];
  logic [31:0]      data_q;
  logic [7:0]       sh_q;
  logic             bit_in_q;
  logic [2:0]       bit_cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       idx_q, last_q;
  logic             rd_q;

  wire              hi_zero = (bus_addr[ADDR_W-1:8] == '0);
  wire [5:0]        word    = bus_addr[7:2];
  wire [CS_W-1:0]   win_cs  = bus_addr[WIN_BITS +: CS_W];
  wire              unused_addr = ^bus_addr[1:0];
  wire              accept  = bus_req && !bus_ready && (st_q == ST_IDLE);

  logic        win_ok, cur_wen;
  logic [31:0] cur_ctrl, reg_rd;
  always_comb begin
    win_ok   = 1'b0;
    cur_wen  = 1'b0;
    cur_ctrl = '0;
    reg_rd   = '0;
    if (hi_zero && word == W_CONF) reg_rd = conf_q;
    if (hi_zero && word == W_STAT) reg_rd = STAT_RST;
    for (int i = 0; i < NUM_CS; i++) begin
      if (win_cs == CS_W'(i)) begin
        win_ok   = 1'b1;
        cur_ctrl = ctrl_q[i];
        cur_wen  = conf_q[WEN_LSB + i];
      end
      if (hi_zero && word == W_CTRL0 + 6'(i)) reg_rd = ctrl_q[i];
    end
  end

  wire user_mode = (cur_ctrl[1:0] == MODE_USER);

  logic [7:0]  sh_next, next_tx;
  logic [31:0] merged;
  always_comb begin
    sh_next = {sh_q[6:0], bit_in_q};
    merged  = data_q;
    merged[{idx_q, 3'b000} +: 8] = sh_next;
    next_tx = data_q[{idx_q + 2'd1, 3'b000} +: 8];
  end

  assign spi_mosi = sh_q[7];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign spi_cs_n[g] = ctrl_q[g][2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      conf_q    <= '0;
      for (int i = 0; i < NUM_CS; i++) ctrl_q[i] <= CTRL_RST;
      data_q    <= '0;
      sh_q      <= '0;
      bit_in_q  <= 1'b0;
      bit_cnt_q <= '0;
      div_q     <= '0;
      idx_q     <= '0;
      last_q    <= '0;
      rd_q      <= 1'b0;
      spi_sck   <= 1'b0;
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          if (!bus_win) begin
            bus_ready <= 1'b1;
            if (bus_we) begin
              if (hi_zero && word == W_CONF) conf_q <= bus_wdata;
              for (int i = 0; i < NUM_CS; i++)
                if (hi_zero && word == W_CTRL0 + 6'(i)) ctrl_q[i] <= bus_wdata;
            end else begin
              bus_rdata <= reg_rd;
            end
          end else if (!win_ok) begin
            bus_ready <= 1'b1;
            if (!bus_we) bus_rdata <= '0;
          end else if (!bus_we && !user_mode) begin
            bus_ready <= 1'b1;
            bus_rdata <= '1;
          end else if (bus_we && (!cur_wen || !user_mode)) begin
            bus_ready <= 1'b1;
          end else begin
            st_q      <= ST_SHIFT;
            rd_q      <= !bus_we;
            last_q    <= bus_size;
            idx_q     <= '0;
            data_q    <= bus_we ? bus_wdata : 32'h0;
            sh_q      <= bus_we ? bus_wdata[7:0] : 8'h00;
            div_q     <= '0;
            bit_cnt_q <= '0;
            spi_sck   <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (div_q != DIV_LAST) begin
            div_q <= div_q + 1'b1;
          end else begin
            div_q <= '0;
            if (!spi_sck) begin
              spi_sck  <= 1'b1;
              bit_in_q <= spi_miso;
            end else begin
              spi_sck <= 1'b0;
              if (bit_cnt_q != 3'd7) begin
                bit_cnt_q <= bit_cnt_q + 3'd1;
                sh_q      <= sh_next;
              end else begin
                bit_cnt_q <= '0;
                if (rd_q) data_q <= merged;
                if (idx_q == last_q) begin
                  st_q      <= ST_IDLE;
                  bus_ready <= 1'b1;
                  if (rd_q) bus_rdata <= merged;
                end else begin
                  idx_q <= idx_q + 2'd1;
                  sh_q  <= rd_q ? 8'h00 : next_tx;
                end
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_user_port_chk.sv
module spi_user_port_chk #(
  parameter int NUM_CS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ready,
  input logic              spi_sck,
  input logic [NUM_CS-1:0] spi_cs_n
);
  logic       sck_d;
  logic [2:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sck_d <= spi_sck;
      if (spi_sck && !sck_d) rise_cnt <= rise_cnt + 3'd1;
    end
  end

  assert_reset_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&spi_cs_n));

  assert_cs_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_cs_n) |-> bus_ready);

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  assert_whole_bytes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> (rise_cnt == 3'd0));

  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> !spi_sck);
endmodule

bind spi_user_port spi_user_port_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n)
);

// File: tb/spi_user_port_bench.sv
module spi_user_port_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCS = 3;
  localparam int DIV = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_win = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_ready, spi_sck, spi_mosi, spi_miso;
  logic [NCS-1:0] spi_cs_n;

  spi_user_port #(.NUM_CS(NCS), .ADDR_W(16), .WIN_BITS(12), .CLK_DIV(DIV)) u_spi_user_port (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_win(bus_win), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0, cyc_all = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      mismatched++;
      $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
    end
  end

  // flash responder: byte stream varies with position
  function automatic logic [7:0] resp(input int k);
    return 8'(k * 29 + 8'h5A) ^ 8'(k << 4);
  endfunction

  int      tot_bits = 0;
  logic [7:0] cap = '0;
  logic [7:0] got_q[$];
  realtime last_rise = 0.0;
  logic [7:0] rb;
  always_comb begin
    rb = resp(tot_bits / 8);
    spi_miso = rb[7 - (tot_bits % 8)];
  end

  always @(posedge spi_sck) begin
    if (tot_bits % 8 != 0)
      chk(int'(($realtime - last_rise) * 1000.0) == 2 * DIV * 5000, "R9 sck period",
          int'(($realtime - last_rise) * 1000.0), 2 * DIV * 5000);
    last_rise = $realtime;
    cap = {cap[6:0], spi_mosi};
    tot_bits++;
    if (tot_bits % 8 == 0) got_q.push_back(cap);
  end

  // model of the register words, compared on every clock
  logic [31:0] exp_conf = '0;
  logic [31:0] exp_ctrl [NCS];
  bit          cur_regwr = 0, in_win = 0;
  logic [15:0] cur_addr = '0;
  logic [31:0] cur_wd = '0;
  initial for (int i = 0; i < NCS; i++) exp_ctrl[i] = 32'h4;

  always @(negedge clk) if (rst_n) begin
    if (bus_ready && cur_regwr && cur_addr[15:8] == 0) begin
      if (cur_addr[7:2] == 0) exp_conf = cur_wd;
      for (int i = 0; i < NCS; i++) if (int'(cur_addr[7:2]) == 4 + i) exp_ctrl[i] = cur_wd;
    end
    for (int i = 0; i < NCS; i++)
      chk(spi_cs_n[i] == exp_ctrl[i][2], "R3 cs level", spi_cs_n[i], exp_ctrl[i][2]);
    if (!in_win) chk(spi_sck == 1'b0, "R9 sck idle", spi_sck, 0);
  end

  task automatic acc(input bit win, input bit we, input logic [15:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int n);
    @(negedge clk);
    cur_regwr = !win && we; cur_addr = a; cur_wd = wd; in_win = win;
    bus_win = win; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd; bus_req = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_ready);
    rd = bus_rdata;
    bus_req = 1'b0;
    in_win = 0;
  endtask

  function automatic logic [15:0] win_a(input int cs);
    return 16'(cs << 12);
  endfunction

  task automatic win_read(input int cs, input int nb, input string rq);
    logic [31:0] rd, exp; int n, b0, q0;
    b0 = tot_bits / 8; q0 = got_q.size();
    exp = '0;
    for (int k = 0; k < nb; k++) exp[8*k +: 8] = resp(b0 + k);
    acc(1, 0, win_a(cs), 2'(nb - 1), 32'h0, rd, n);
    chk(rd == exp, rq, rd, exp);
    chk(n == 1 + 16 * DIV * nb, "R10 read latency", n, 1 + 16 * DIV * nb);
    chk(got_q.size() == q0 + nb, "R5 byte count", got_q.size(), q0 + nb);
    for (int k = 0; k < nb; k++) chk(got_q[q0 + k] == 8'h00, "R5 sends zero", got_q[q0 + k], 0);
  endtask

  task automatic win_write(input int cs, input int nb, input logic [31:0] wd, input string rq);
    logic [31:0] rd; int n, q0;
    q0 = got_q.size();
    acc(1, 1, win_a(cs), 2'(nb - 1), wd, rd, n);
    chk(n == 1 + 16 * DIV * nb, "R10 write latency", n, 1 + 16 * DIV * nb);
    chk(got_q.size() == q0 + nb, rq, got_q.size(), q0 + nb);
    for (int k = 0; k < nb; k++) chk(got_q[q0 + k] == wd[8*k +: 8], rq, got_q[q0 + k], wd[8*k +: 8]);
  endtask

  task automatic quiet(input bit we, input logic [15:0] a, input logic [31:0] exp_rd, input string rq);
    logic [31:0] rd; int n, t0;
    t0 = tot_bits;
    acc(1, we, a, 2'd3, 32'hA1B2C3D4, rd, n);
    chk(tot_bits == t0, {rq, " no sck"}, tot_bits, t0);
    chk(n == 1, {rq, " completes"}, n, 1);
    if (!we) chk(rd == exp_rd, rq, rd, exp_rd);
  endtask

  task automatic rreg(input logic [15:0] a, input logic [31:0] exp, input string rq);
    logic [31:0] rd; int n;
    acc(0, 0, a, 2'd0, 32'h0, rd, n);
    chk(rd == exp, rq, rd, exp);
    chk(n == 1, "R10 reg latency", n, 1);
  endtask

  task automatic wreg(input logic [15:0] a, input logic [31:0] wd);
    logic [31:0] rd; int n;
    acc(0, 1, a, 2'd0, wd, rd, n);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == '1, "R1 cs_n after reset", spi_cs_n, '1);
    chk(spi_sck == 1'b0, "R1 sck after reset", spi_sck, 0);
    rreg(16'h00, 32'h0, "R1 conf reset");
    rreg(16'h08, 32'h800, "R1 status reset");
    for (int i = 0; i < NCS; i++) rreg(16'(16 + 4 * i), 32'h4, "R1 ctrl reset");
    rreg(16'h04, 32'h0, "R2 unmapped read");
    rreg(16'h40, 32'h0, "R2 unmapped read high");
    wreg(16'h08, 32'hFFFF_FFFF);
    rreg(16'h08, 32'h800, "R2 status read-only");
    wreg(16'h0C, 32'h1234_5678);
    rreg(16'h0C, 32'h0, "R2 unmapped write ignored");
    rreg(16'h100, 32'h0, "R2 upper address bits");

    wreg(16'h14, 32'h00AB_0003);
    rreg(16'h14, 32'h00AB_0003, "R4 opcode and mode readback");
    win_read(1, 4, "R5 four-byte read");
    win_read(1, 1, "R5 one-byte read");
    win_read(1, 2, "R5 two-byte read");
    quiet(1, win_a(1), 32'h0, "R7 write without enable");

    wreg(16'h00, 32'h0002_0000);
    rreg(16'h00, 32'h0002_0000, "R2 conf readback");
    win_write(1, 4, 32'hDEADBEEF, "R6 four-byte write");
    win_write(1, 3, 32'h0012_3456, "R6 three-byte write");
    wreg(16'h14, 32'h00AB_0007);

    quiet(0, win_a(0), 32'hFFFF_FFFF, "R8 read in read mode");
    wreg(16'h10, 32'h0000_0001);
    quiet(0, win_a(0), 32'hFFFF_FFFF, "R8 read in fast-read mode");
    wreg(16'h00, 32'h0003_0000);
    wreg(16'h10, 32'h0000_0002);
    quiet(1, win_a(0), 32'h0, "R7 write in write mode");

    quiet(0, win_a(3), 32'h0, "R11 read past last cs");
    quiet(1, win_a(3), 32'h0, "R11 write past last cs");

    wreg(16'h18, 32'h0000_0003);
    win_read(2, 3, "R11 read through cs2");
    wreg(16'h00, 32'h0004_0000);
    win_write(2, 2, 32'h0000_9A7C, "R11 write through cs2");
    quiet(1, win_a(1), 32'h0, "R7 cs1 enable cleared");
    wreg(16'h18, 32'h0000_0007);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule